// File: doc/BRIEF.md
# Six-Channel Memory DMA Engine

The engine copies data between memory locations on behalf of up to six independent channels. Software programs each channel through a 32-bit register window: a source address, a destination address, a unit count, a request-type code and a control/status word. Once the global enable and the channel enable are set, the channel moves one unit at a time. It runs back to back for memory-to-memory work, or paces itself on a per-peripheral request line. The request-type code alone decides whether each address steps forward and what port widths are reported. When the count reaches zero the channel raises its completion flag and, if allowed, its interrupt.

Data moves over a word-wide master port made of a read-request channel, a read-response channel and a write channel. A request holds its address, and for writes its data and byte strobes, until the memory raises ready. Only one read is outstanding at a time, and a response is accepted in any cycle it is offered. Sub-word units are carried by selecting a byte or halfword lane and writing it with a strobe. Units of 16 and 32 bytes are split into 4 or 8 word read/write pairs at consecutive addresses.

Top module: `memdma_engine`

## Requirements
- R1: After reset every register reads zero, irq is low and neither rd_req_valid nor wr_valid is asserted.
- R2: Channel n (0..5) decodes at byte offset n*0x20: source at +0x00, destination at +0x04, count at +0x08, request type at +0x0C and control/status at +0x10. The count keeps only bits 23:0 and the request type keeps only bits 4:0.
- R3: With request type 8 the channel moves units back to back. Source and destination each advance by the unit size in bytes after every unit, and the final addresses stay readable.
- R4: The request-type code sets read-only control/status fields: bit 23 is source increment, bit 22 is destination increment, bits 15:14 are source width and bits 13:12 are destination width (width 1 = 8-bit, 0 = 32-bit). Codes 8 and 28 step both addresses. Other even codes of 4 or more step the source, and other odd codes of 5 or more step the destination. Codes 0 to 3 step neither. The source width is 8-bit for codes 15, 17, 19 and 21, and the destination width is 8-bit for codes 14, 16, 18 and 20. A channel whose code is not 8 moves only while peri_req[code] is high.
- R5: The count drops by one per unit. When it reaches zero, control/status bit 3 (completed) is set. irq[n] is high exactly when bit 3 and bit 1 (interrupt enable) of channel n are both set, and the pending register at 0xF8 shows irq[n] at bit 15-n.
- R6: Writing control/status with bit 3 at 0 clears the completed flag and the interrupt. The count and addresses left by the transfer stay readable until they are rewritten.
- R7: A channel moves data only while global control (0xFC) bit 0 (enable) is 1, bits 3 (halt) and 2 (address error) are 0, and its own bit 0 (enable) is 1 with bits 2 (halt) and 4 (address error) at 0.
- R8: A read request keeps rd_req_valid and rd_req_addr, and a write keeps wr_valid, wr_addr, wr_data and wr_strb, unchanged until the matching ready is seen high.
- R9: When several channels are ready, the lowest-numbered one is granted, one unit per grant. Two auto channels started together therefore finish the lower one's units first.
- R10: A source or destination address that is misaligned for the unit size sets channel bit 4 and global bit 2, and no memory access is made for it. Half-words need bit 0 clear; words and bursts need bits 1:0 clear; bytes never fault. Writing 0 to each of those bits clears it.
- R11: Unit size is control/status bits 10:8: 0 = 32-bit, 1 = 8-bit, 2 = 16-bit, 3 = 16-byte, 4 = 32-byte. An 8-bit or 16-bit unit is taken from the lane given by the low source address bits and written to the lane given by the low destination address bits with a matching strobe. A 16-byte unit moves 4 words and a 32-byte unit moves 8 words at consecutive word addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| peri_req | input | 32 | Peripheral request lines, indexed by request type |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Word-aligned read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Word-aligned write address |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Byte strobes, lane b is address+b |
| irq | output | 6 | Per-channel interrupt |

## Verification
A wrong channel register shows within one unit: the next read or write address leaves the expected sequence, or the destination bytes differ from a byte-level copy computed from the requirements. A lost or extra count decrement shows when the transfer ends, as a completion flag that arrives too early or never, a wrong number of moved bytes, or wrong final addresses. A broken grant order shows in the order of write addresses. A broken handshake shows on the very next clock, as an address or data word that changes while ready is low.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {MV_IDLE, MV_RD, MV_WAIT, MV_WR, MV_DONE} mv_state_e;

  localparam logic [4:0] REQ_AUTO     = 5'd8;
  localparam logic [4:0] REQ_BOTH_INC = 5'd28;

  function automatic logic [3:0] words_of(input logic [2:0] sz);
    case (sz)
      3'd3:    return 4'd4;
      3'd4:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [5:0] bytes_of(input logic [2:0] sz);
    case (sz)
      3'd1:    return 6'd1;
      3'd2:    return 6'd2;
      3'd3:    return 6'd16;
      3'd4:    return 6'd32;
      default: return 6'd4;
    endcase
  endfunction

  function automatic logic steps_src(input logic [4:0] rt);
    return (rt == REQ_AUTO) || (rt == REQ_BOTH_INC) || (rt >= 5'd4 && !rt[0]);
  endfunction

  function automatic logic steps_dst(input logic [4:0] rt);
    return (rt == REQ_AUTO) || (rt == REQ_BOTH_INC) || (rt >= 5'd4 && rt[0]);
  endfunction

  function automatic logic [1:0] width_src(input logic [4:0] rt);
    return (rt inside {5'd15, 5'd17, 5'd19, 5'd21}) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [1:0] width_dst(input logic [4:0] rt);
    return (rt inside {5'd14, 5'd16, 5'd18, 5'd20}) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic misaligned(input logic [1:0] a, input logic [2:0] sz);
    case (sz)
      3'd1:    return 1'b0;
      3'd2:    return a[0];
      default: return a != 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int REQ_W  = 5,
  parameter int PREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic [PREQ_W-1:0] preq,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              upd_hit,
  input  logic [31:0]       upd_src,
  input  logic [31:0]       upd_dst,
  input  logic              err_hit,
  output logic [31:0]       src_o,
  output logic [31:0]       dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [REQ_W-1:0]  rtype_o,
  output logic [2:0]        size_o,
  output logic [31:0]       cs_o,
  output logic              ready_o,
  output logic              irq_o
);

  logic en, ie, halt, done, err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o <= '0; dst_o <= '0; cnt_o <= '0; rtype_o <= '0; size_o <= '0;
      en <= 1'b0; ie <= 1'b0; halt <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      if (upd_hit) begin
        src_o <= upd_src;
        dst_o <= upd_dst;
        cnt_o <= cnt_o - CNT_W'(1);
        if (cnt_o == CNT_W'(1)) done <= 1'b1;
      end
      if (err_hit) err <= 1'b1;
      if (wr_en) begin
        case (wr_sel)
          3'd0: src_o   <= wr_data;
          3'd1: dst_o   <= wr_data;
          3'd2: cnt_o   <= wr_data[CNT_W-1:0];
          3'd3: rtype_o <= wr_data[REQ_W-1:0];
          3'd4: begin
            en     <= wr_data[0];
            ie     <= wr_data[1];
            halt   <= wr_data[2];
            done   <= done & wr_data[3];
            err    <= err & wr_data[4];
            size_o <= wr_data[10:8];
          end
          default: ;
        endcase
      end
    end
  end

  logic [4:0] rt5;
  assign rt5 = 5'(rtype_o);

  assign cs_o = {8'b0, steps_src(rt5), steps_dst(rt5), 6'b0,
                 width_src(rt5), width_dst(rt5), 1'b0, size_o,
                 1'b0, 2'b0, err, done, halt, ie, en};

  assign ready_o = run_ok && en && !halt && !err && !done && (cnt_o != '0) &&
                   ((rt5 == REQ_AUTO) || preq[rtype_o]);
  assign irq_o   = done && ie;

  a_r5_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && cnt_o == CNT_W'(1) && !wr_en) |=> done);

  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hit && !wr_en) |=> (err && !ready_o));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N    = 6,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);

  always_comb begin
    logic taken;
    taken   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
        taken   = 1'b1;
      end
    end
  end

  assign gnt_any = |req;

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  a_r9_served: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(gnt) == 1));

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_any,
  input  logic [IW-1:0] gnt_idx,
  input  logic [31:0]   sel_src,
  input  logic [31:0]   sel_dst,
  input  logic [2:0]    sel_size,
  input  logic [4:0]    sel_rtype,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [31:0]   rd_req_addr,
  input  logic          rd_resp_valid,
  input  logic [31:0]   rd_resp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [31:0]   wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_strb,
  output logic          upd_valid,
  output logic [IW-1:0] upd_ch,
  output logic [31:0]   upd_src,
  output logic [31:0]   upd_dst,
  output logic          err_valid,
  output logic [IW-1:0] err_ch
);

  mv_state_e     st;
  logic [IW-1:0] ch_q;
  logic [31:0]   sbase, dbase, scur, dcur, data_q;
  logic [2:0]    size_q;
  logic          sinc_q, dinc_q;
  logic [3:0]    left_q;
  logic          bad_addr;

  assign bad_addr  = misaligned(sel_src[1:0], sel_size) || misaligned(sel_dst[1:0], sel_size);
  assign err_valid = (st == MV_IDLE) && gnt_any && bad_addr;
  assign err_ch    = gnt_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= MV_IDLE; ch_q <= '0; sbase <= '0; dbase <= '0; scur <= '0; dcur <= '0;
      data_q <= '0; size_q <= '0; sinc_q <= 1'b0; dinc_q <= 1'b0; left_q <= '0;
    end else begin
      case (st)
        MV_IDLE: if (gnt_any && !bad_addr) begin
          ch_q   <= gnt_idx;
          sbase  <= sel_src;  scur <= sel_src;
          dbase  <= sel_dst;  dcur <= sel_dst;
          size_q <= sel_size;
          sinc_q <= steps_src(sel_rtype);
          dinc_q <= steps_dst(sel_rtype);
          left_q <= words_of(sel_size);
          st     <= MV_RD;
        end
        MV_RD:   if (rd_req_ready) st <= MV_WAIT;
        MV_WAIT: if (rd_resp_valid) begin
          data_q <= rd_resp_data;
          st     <= MV_WR;
        end
        MV_WR:   if (wr_ready) begin
          left_q <= left_q - 4'd1;
          if (sinc_q) scur <= scur + 32'd4;
          if (dinc_q) dcur <= dcur + 32'd4;
          st <= (left_q == 4'd1) ? MV_DONE : MV_RD;
        end
        MV_DONE: st <= MV_IDLE;
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == MV_RD);
  assign rd_req_addr  = {scur[31:2], 2'b00};
  assign wr_valid     = (st == MV_WR);
  assign wr_addr      = {dcur[31:2], 2'b00};

  always_comb begin
    logic [31:0] sh;
    case (size_q)
      3'd1: begin
        sh      = data_q >> {scur[1:0], 3'b000};
        wr_data = {4{sh[7:0]}};
        wr_strb = 4'b0001 << dcur[1:0];
      end
      3'd2: begin
        sh      = data_q >> {scur[1], 4'b0000};
        wr_data = {2{sh[15:0]}};
        wr_strb = dcur[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        sh      = data_q;
        wr_data = data_q;
        wr_strb = 4'b1111;
      end
    endcase
  end

  assign upd_valid = (st == MV_DONE);
  assign upd_ch    = ch_q;
  assign upd_src   = sbase + (sinc_q ? 32'(bytes_of(size_q)) : 32'd0);
  assign upd_dst   = dbase + (dinc_q ? 32'(bytes_of(size_q)) : 32'd0);

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)));

endmodule

// File: rtl/memdma_engine.sv
module memdma_engine
  import dma_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 24,
  parameter int REQ_W  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] peri_req,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_resp_valid,
  input  logic [31:0] rd_resp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_strb,
  output logic [5:0]  irq
);

  localparam int IW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PREQ_W   = 1 << REQ_W;
  localparam int PEND_TOP = 15;
  localparam logic [7:0] OFF_PEND = 8'hF8;
  localparam logic [7:0] OFF_GCTL = 8'hFC;

  logic g_en, g_halt, g_err;
  logic [1:0] g_prio;
  logic run_ok;

  logic [NUM_CH-1:0][31:0]      c_src, c_dst, c_cs;
  logic [NUM_CH-1:0][CNT_W-1:0] c_cnt;
  logic [NUM_CH-1:0][REQ_W-1:0] c_rt;
  logic [NUM_CH-1:0][2:0]       c_size;
  logic [NUM_CH-1:0]            c_rdy, c_irq, c_wr, c_upd, c_err, gnt;

  logic [IW-1:0] gnt_idx, upd_ch, err_ch;
  logic          gnt_any, upd_valid, err_valid;
  logic [31:0]   upd_src, upd_dst, sel_src, sel_dst;
  logic [2:0]    sel_size;
  logic [4:0]    sel_rtype;

  assign run_ok = g_en && !g_halt && !g_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en <= 1'b0; g_halt <= 1'b0; g_err <= 1'b0; g_prio <= '0;
    end else begin
      if (err_valid) g_err <= 1'b1;
      if (cfg_we && cfg_addr == OFF_GCTL) begin
        g_en   <= cfg_wdata[0];
        g_halt <= cfg_wdata[3];
        g_err  <= g_err & cfg_wdata[2];
        g_prio <= cfg_wdata[9:8];
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign c_wr[i]  = cfg_we && cfg_addr[7:5] == 3'(i) && cfg_addr[4:2] <= 3'd4;
    assign c_upd[i] = upd_valid && upd_ch == IW'(i);
    assign c_err[i] = err_valid && err_ch == IW'(i);

    dma_chan_regs #(.CNT_W(CNT_W), .REQ_W(REQ_W), .PREQ_W(PREQ_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .preq(PREQ_W'(peri_req)),
      .wr_en(c_wr[i]), .wr_sel(cfg_addr[4:2]), .wr_data(cfg_wdata),
      .upd_hit(c_upd[i]), .upd_src(upd_src), .upd_dst(upd_dst), .err_hit(c_err[i]),
      .src_o(c_src[i]), .dst_o(c_dst[i]), .cnt_o(c_cnt[i]), .rtype_o(c_rt[i]),
      .size_o(c_size[i]), .cs_o(c_cs[i]), .ready_o(c_rdy[i]), .irq_o(c_irq[i])
    );

    assign irq[i] = c_irq[i];
  end

  for (genvar j = NUM_CH; j < 6; j++) begin : g_irq_pad
    assign irq[j] = 1'b0;
  end

  dma_prio_arb #(.N(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(c_rdy), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  always_comb begin
    sel_src = '0; sel_dst = '0; sel_size = '0; sel_rtype = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt[i]) begin
        sel_src   = c_src[i];
        sel_dst   = c_dst[i];
        sel_size  = c_size[i];
        sel_rtype = 5'(c_rt[i]);
      end
    end
  end

  dma_mover #(.IW(IW)) u_mover (
    .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
    .sel_src(sel_src), .sel_dst(sel_dst), .sel_size(sel_size), .sel_rtype(sel_rtype),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_src(upd_src),
    .upd_dst(upd_dst), .err_valid(err_valid), .err_ch(err_ch)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_PEND) begin
      for (int i = 0; i < NUM_CH; i++) cfg_rdata[PEND_TOP - i] = c_irq[i];
    end else if (cfg_addr == OFF_GCTL) begin
      cfg_rdata = {22'b0, g_prio, 4'b0, g_halt, g_err, 1'b0, g_en};
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (cfg_addr[7:5] == 3'(i)) begin
          case (cfg_addr[4:2])
            3'd0: cfg_rdata = c_src[i];
            3'd1: cfg_rdata = c_dst[i];
            3'd2: cfg_rdata = 32'(c_cnt[i]);
            3'd3: cfg_rdata = 32'(c_rt[i]);
            3'd4: cfg_rdata = c_cs[i];
            default: ;
          endcase
        end
      end
    end
  end

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && !rd_req_valid && !wr_valid && !upd_valid && $past(!run_ok)) |=> !rd_req_valid);

endmodule

// File: tb/sim_memdma_engine.sv
`timescale 1ns/1ps
module sim_memdma_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] peri_req = '0;
  logic        rd_req_valid, rd_req_ready, rd_resp_valid;
  logic [31:0] rd_req_addr, rd_resp_data;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_strb;
  logic [5:0]  irq;

  memdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .peri_req(peri_req), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_resp_valid(rd_resp_valid),
    .rd_resp_data(rd_resp_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  mem  [0:1023];
  logic [7:0]  refb [0:1023];
  logic [31:0] wlog [$];
  int          rd_hs = 0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural memory with pseudo-random back-pressure
  assign rd_req_ready = lfsr[0];
  assign wr_ready     = lfsr[3] | lfsr[5];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_resp_valid <= 1'b0;
    if (rst_n && rd_req_valid && rd_req_ready) begin
      int a;
      a = {rd_req_addr[9:2], 2'b00};
      rd_resp_valid <= 1'b1;
      rd_resp_data  <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
      rd_hs++;
    end
    if (rst_n && wr_valid && wr_ready) begin
      int a;
      a = {wr_addr[9:2], 2'b00};
      for (int b = 0; b < 4; b++) if (wr_strb[b]) mem[a+b] <= wr_data[8*b +: 8];
      wlog.push_back(wr_addr);
    end
  end

  // Per-clock handshake monitor (R8)
  logic        pend_rd = 1'b0, pend_wr = 1'b0;
  logic [31:0] prev_ra, prev_wa, prev_wd;
  always @(posedge clk) begin
    if (rst_n) begin
      if (pend_rd) chk("R8 read request held", {rd_req_valid, rd_req_addr[30:0]}, {1'b1, prev_ra[30:0]});
      if (pend_wr) chk("R8 write request held", {wr_valid, wr_addr[30:0] ^ wr_data[30:0]},
                       {1'b1, prev_wa[30:0] ^ prev_wd[30:0]});
    end
    pend_rd <= rst_n && rd_req_valid && !rd_req_ready;
    pend_wr <= rst_n && wr_valid && !wr_ready;
    prev_ra <= rd_req_addr;
    prev_wa <= wr_addr;
    prev_wd <= wr_data;
  end

  task automatic cfg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 8'(a);
    #0.5;
    d = cfg_rdata;
  endtask

  function automatic int ra(input int ch, input int off);
    return ch * 32 + off;
  endfunction

  task automatic wait_done(input int ch, input string tag);
    logic [31:0] v;
    for (int t = 0; t < 3000; t++) begin
      cfg_rd(ra(ch, 16), v);
      if (v[3]) return;
    end
    chk(tag, v[3], 1'b1);
  endtask

  task automatic ref_copy(input int s, input int d, input int ub, input int n, input bit si, input bit di);
    for (int u = 0; u < n; u++)
      for (int b = 0; b < ub; b++)
        refb[(d + (di ? u*ub : 0) + b) & 1023] = refb[(s + (si ? u*ub : 0) + b) & 1023];
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refb[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic setup(input int ch, input int s, input int d, input int n, input int rt);
    cfg_wr(ra(ch, 0), s);
    cfg_wr(ra(ch, 4), d);
    cfg_wr(ra(ch, 8), n);
    cfg_wr(ra(ch, 12), rt);
  endtask

  task automatic run_auto(input int ch, input int s, input int d, input int n, input int sz,
                          input int ub, input string tag);
    logic [31:0] v;
    setup(ch, s, d, n, 8);
    cfg_wr(ra(ch, 16), 32'h1 | (sz << 8));
    wait_done(ch, {tag, " completion"});
    ref_copy(s, d, ub, n, 1, 1);
    mem_cmp({tag, " memory contents"});
    cfg_rd(ra(ch, 0), v); chk({tag, " final source"}, v, s + n*ub);
    cfg_rd(ra(ch, 4), v); chk({tag, " final destination"}, v, d + n*ub);
    cfg_wr(ra(ch, 16), 0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'((i * 7 + 3) & 255);
      refb[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cfg_rd(8'hFC, v);     chk("R1 global control after reset", v, 0);
    cfg_rd(8'hF8, v);     chk("R1 pending after reset", v, 0);
    cfg_rd(ra(0, 16), v); chk("R1 channel 0 control after reset", v, 32'h00C00000 & 32'h0);
    chk("R1 irq and bus idle", {irq, rd_req_valid, wr_valid}, 0);

    // R2: register map and field widths
    cfg_wr(ra(3, 0), 32'h1234_5678);
    cfg_rd(ra(3, 0), v);  chk("R2 channel 3 source", v, 32'h1234_5678);
    cfg_wr(ra(3, 8), 32'hFFFF_FFFF);
    cfg_rd(ra(3, 8), v);  chk("R2 count keeps 24 bits", v, 32'h00FF_FFFF);
    cfg_wr(ra(3, 12), 32'hFFFF_FFE9);
    cfg_rd(ra(3, 12), v); chk("R2 request type keeps 5 bits", v, 32'h9);
    cfg_rd(ra(2, 0), v);  chk("R2 neighbour channel untouched", v, 0);
    cfg_wr(ra(3, 8), 0);

    // R7: gating by global enable and halt
    setup(0, 32'h0E0, 32'h3D0, 2, 8);
    cfg_wr(ra(0, 16), 32'h1);
    repeat (20) @(negedge clk);
    cfg_rd(ra(0, 8), v);  chk("R7 no movement while global enable clear", {v, 16'(rd_hs)}, 0 | 48'h2_0000);
    cfg_wr(8'hFC, 32'h9);
    repeat (20) @(negedge clk);
    cfg_rd(ra(0, 8), v);  chk("R7 no movement while global halt set", v, 2);
    chk("R7 no reads while halted", rd_hs, 0);
    cfg_wr(8'hFC, 32'h1);
    wait_done(0, "R7 completion after release");
    ref_copy(32'h0E0, 32'h3D0, 4, 2, 1, 1);
    mem_cmp("R7 memory after release");
    cfg_wr(ra(0, 16), 0);

    // R3, R5, R6: 32-bit auto transfer with interrupt
    setup(0, 32'h000, 32'h200, 4, 8);
    cfg_wr(ra(0, 16), 32'h3);
    wait_done(0, "R5 completion");
    @(negedge clk);
    ref_copy(0, 32'h200, 4, 4, 1, 1);
    mem_cmp("R3 memory contents");
    cfg_rd(ra(0, 0), v);  chk("R3 final source", v, 32'h010);
    cfg_rd(ra(0, 4), v);  chk("R3 final destination", v, 32'h210);
    cfg_rd(ra(0, 8), v);  chk("R5 count reaches zero", v, 0);
    cfg_rd(ra(0, 16), v); chk("R5 control/status after completion", v, 32'h00C0_000B);
    chk("R5 irq for channel 0", irq, 6'b000001);
    cfg_rd(8'hF8, v);     chk("R5 pending bit 15", v, 32'h8000);
    cfg_wr(ra(0, 16), 32'h3);
    cfg_rd(ra(0, 16), v); chk("R6 completed flag cleared", v[3], 0);
    chk("R6 irq dropped", irq, 0);
    cfg_rd(ra(0, 4), v);  chk("R6 destination still readable", v, 32'h210);
    cfg_wr(ra(0, 16), 0);

    // R11: sub-word lanes and bursts
    run_auto(1, 32'h041, 32'h303, 5, 1, 1, "R11 byte units");
    run_auto(2, 32'h082, 32'h3A2, 3, 2, 2, "R11 halfword units");
    wlog.delete();
    run_auto(0, 32'h0C0, 32'h340, 2, 3, 16, "R11 16-byte bursts");
    chk("R11 16-byte burst word writes", wlog.size(), 8);
    if (wlog.size() >= 8) chk("R11 burst addresses consecutive", wlog[7] - wlog[4], 12);
    wlog.delete();
    run_auto(4, 32'h000, 32'h380, 1, 4, 32, "R11 32-byte burst");
    chk("R11 32-byte burst word writes", wlog.size(), 8);

    // R4: request-type decode and peripheral pacing
    cfg_wr(ra(4, 12), 16);
    cfg_rd(ra(4, 16), v); chk("R4 code 16 fields", {v[23:22], v[15:12]}, 6'b10_0001);
    cfg_wr(ra(4, 12), 2);
    cfg_rd(ra(4, 16), v); chk("R4 code 2 fields", {v[23:22], v[15:12]}, 6'b00_0000);
    cfg_wr(ra(4, 12), 28);
    cfg_rd(ra(4, 16), v); chk("R4 code 28 fields", {v[23:22], v[15:12]}, 6'b11_0000);
    setup(5, 32'h010, 32'h3C0, 3, 17);
    cfg_wr(ra(5, 16), 32'h1);
    cfg_rd(ra(5, 16), v); chk("R4 code 17 fields", {v[23:22], v[15:12]}, 6'b01_0100);
    repeat (20) @(negedge clk);
    cfg_rd(ra(5, 8), v);  chk("R4 waits for its request line", v, 3);
    peri_req = 32'h1 << 17;
    wait_done(5, "R4 completion on request line");
    peri_req = '0;
    ref_copy(32'h010, 32'h3C0, 4, 3, 0, 1);
    mem_cmp("R4 fixed source memory");
    cfg_rd(ra(5, 0), v);  chk("R4 source not stepped", v, 32'h010);
    cfg_rd(ra(5, 4), v);  chk("R4 destination stepped", v, 32'h3CC);
    cfg_wr(ra(5, 16), 0);

    // R9: fixed priority
    cfg_wr(8'hFC, 32'h0);
    setup(3, 32'h030, 32'h3F0, 2, 8);
    setup(1, 32'h020, 32'h3E0, 2, 8);
    cfg_wr(ra(3, 16), 32'h1);
    cfg_wr(ra(1, 16), 32'h1);
    wlog.delete();
    cfg_wr(8'hFC, 32'h1);
    wait_done(3, "R9 channel 3 completion");
    chk("R9 write count", wlog.size(), 4);
    if (wlog.size() == 4) begin
      chk("R9 first grant to channel 1", wlog[0], 32'h3E0);
      chk("R9 channel 1 finishes first", wlog[1], 32'h3E4);
      chk("R9 then channel 3", wlog[2], 32'h3F0);
    end
    ref_copy(32'h020, 32'h3E0, 4, 2, 1, 1);
    ref_copy(32'h030, 32'h3F0, 4, 2, 1, 1);
    mem_cmp("R9 memory contents");
    cfg_wr(ra(1, 16), 0);
    cfg_wr(ra(3, 16), 0);

    // R10: misaligned address
    wlog.delete();
    rd_hs = 0;
    setup(2, 32'h002, 32'h300, 1, 8);
    cfg_wr(ra(2, 16), 32'h1);
    repeat (10) @(negedge clk);
    cfg_rd(ra(2, 16), v); chk("R10 channel error flag", v[4], 1);
    cfg_rd(8'hFC, v);     chk("R10 global error flag", v[2], 1);
    chk("R10 no memory access", rd_hs + wlog.size(), 0);
    cfg_rd(ra(2, 8), v);  chk("R10 count unchanged", v, 1);
    cfg_wr(8'hFC, 32'h1);
    cfg_rd(8'hFC, v);     chk("R10 global error cleared", v, 1);
    cfg_wr(ra(2, 16), 0);
    cfg_rd(ra(2, 16), v); chk("R10 channel error cleared", v[4], 0);
    mem_cmp("R10 memory untouched");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule